// File: doc/BRIEF.md
# Transmit DMA Channel Run Control

This block holds the configuration and run state for eight transmit DMA channels. Software writes one configuration word per channel over a simple register bus. Each word selects an enable mode and sets an internal-request enable bit. From these settings and the channel's frame activity, a per-channel state machine decides whether the channel's run output is asserted. Descriptor fetch and data movement live in the neighbouring engine, which follows `chan_run`.

A shared status word reports two flags for each channel. One flag says the channel's buffers are empty. The other says the channel has no requests pending. A channel counts as idle only when both flags are set. To stop a channel, software writes zero to its configuration word and then polls the status word until that channel reads idle. A gentler stop mode lets a channel finish the frame it is sending before it releases its run output.

Each channel has its own state machine with three states:

- `CH_OFF`: not running.
- `CH_RUN`: running normally.
- `CH_DRAIN`: finishing the current frame before stopping.

The state machine has these transitions:

- GO: `CH_OFF`→`CH_RUN` when the mode is run.
- HALT: `CH_RUN`→`CH_OFF` when the mode is stop or the unused code.
- SOFT_IDLE: `CH_RUN`→`CH_OFF` when the mode is pause-at-frame-end and no frame is open.
- SOFT_BUSY: `CH_RUN`→`CH_DRAIN` when the mode is pause-at-frame-end and a frame is open with no end this cycle.
- DONE: `CH_DRAIN`→`CH_OFF` on frame end, or when the mode becomes stop.
- RESUME: `CH_DRAIN`→`CH_RUN` when the mode returns to run.

Top module: `txdma_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0, every `chan_run` bit is 0, and every channel is in `CH_OFF`.
- R2: Channel n's configuration word is at byte address 0x20·n. Bits 31:30 hold the mode (00 stop, 01 pause at frame end, 10 run, 11 treated as stop). Bit 3 is the request enable. All other bits discard writes and read back 0.
- R3: A write to one channel's configuration address changes only that channel's configuration and run output.
- R4: With mode 10 and bit 3 set, `chan_run[n]` rises on the second rising clock edge after the write is sampled.
- R5: While bit 3 is clear, `chan_run[n]` is 0 even when the mode is 10.
- R6: Mode 00 or 11 clears a running channel's `chan_run[n]` on the second edge after the write, whether or not a frame is open.
- R7: Mode 01 stops a running channel between frames on the second edge after the write. Mode 01 never starts a stopped channel.
- R8: When mode 01 is written while a frame is open (a `frm_start` pulse was seen with no `frm_end` since), `chan_run[n]` stays 1 until the edge that samples `frm_end[n]`, and is 0 after that edge.
- R9: The status word reads at address 0x100. Its bit 24+n is `buf_empty[n]` and its bit 16+n is the inverse of `req_pend[n]`, both registered on one edge. All other bits read 0. Writes to 0x100 and to unmapped addresses have no effect. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frm_start | input | 8 | Per-channel frame-start pulse |
| frm_end | input | 8 | Per-channel frame-end pulse |
| buf_empty | input | 8 | Per-channel buffers-empty flag |
| req_pend | input | 8 | Per-channel requests-pending flag |
| chan_run | output | 8 | Per-channel run grant |
| status | output | 32 | Shared status word |

## Verification
A wrong state-machine state shows up on `chan_run` within two edges of the configuration write that should have moved it. The clearest case is a channel left in `CH_DRAIN`: it keeps running after the edge that samples its frame end. A lost open-frame flag is the opposite fault: the channel stops at once instead of draining. A stale or misplaced status bit appears on the status read one edge after the flag inputs change. A decode fault appears as a changed run output or readback on a channel that was not addressed.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    localparam logic [1:0] MODE_STOP = 2'b00;
    localparam logic [1:0] MODE_PEOF = 2'b01;
    localparam logic [1:0] MODE_GO   = 2'b10;

    localparam int MODE_MSB     = 31;
    localparam int REQEN_BIT    = 3;
    localparam int EMPTY_LSB    = 24;
    localparam int NOPEND_LSB   = 16;
endpackage

// File: rtl/txdma_cfg_regs.sv
module txdma_cfg_regs
    import txdma_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int STRIDE      = 32,
    parameter int STATUS_ADDR = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        mode_o  [N_CH],
    output logic [N_CH-1:0]   reqen_o
);
    localparam int STRIDE_SH = $clog2(STRIDE);
    localparam int IDX_W     = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CFG_SPAN  = N_CH * STRIDE;

    logic             hit_cfg;
    logic             hit_stat;
    logic [IDX_W-1:0] idx;

    always_comb begin
        hit_cfg  = (int'(addr_i) < CFG_SPAN) && (addr_i[STRIDE_SH-1:0] == '0);
        hit_stat = (int'(addr_i) == STATUS_ADDR);
        idx      = addr_i[STRIDE_SH +: IDX_W];
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_o[g]  <= MODE_STOP;
                reqen_o[g] <= 1'b0;
            end else if (wr_i && hit_cfg && (int'(idx) == g)) begin
                mode_o[g]  <= wdata_i[MODE_MSB -: 2];
                reqen_o[g] <= wdata_i[REQEN_BIT];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_cfg) begin
            rdata_o[MODE_MSB -: 2]  = mode_o[idx];
            rdata_o[REQEN_BIT]      = reqen_o[idx];
        end else if (hit_stat) begin
            rdata_o = status_i;
        end
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg |-> (rdata_o[29:4] == '0 && rdata_o[2:0] == '0));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_cfg && !hit_stat) |-> (rdata_o == '0));
endmodule

// File: rtl/txdma_chan_fsm.sv
module txdma_chan_fsm
    import txdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       reqen_i,
    input  logic       frm_start_i,
    input  logic       frm_end_i,
    output logic       run_o
);
    ch_state_e state_q, state_d;
    logic      in_frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CH_OFF;
            in_frame_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frm_start_i)    in_frame_q <= 1'b1;
            else if (frm_end_i) in_frame_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (mode_i == MODE_GO) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (mode_i == MODE_PEOF)
                    state_d = (in_frame_q && !frm_end_i) ? CH_DRAIN : CH_OFF;
                else if (mode_i != MODE_GO)
                    state_d = CH_OFF;
            end
            CH_DRAIN: begin
                if (mode_i == MODE_GO)        state_d = CH_RUN;
                else if (mode_i != MODE_PEOF) state_d = CH_OFF;
                else if (frm_end_i)           state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        run_o = (state_q != CH_OFF) && reqen_i;
    end

    // R4
    go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_GO) |=> (run_o || !reqen_i));

    // R6
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_STOP || mode_i == 2'b11) |=> !run_o);

    // R8
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DRAIN && mode_i == MODE_PEOF && frm_end_i) |=> (state_q == CH_OFF));

    // R7
    peof_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF && mode_i == MODE_PEOF) |=> (state_q == CH_OFF));
endmodule

// File: rtl/txdma_status.sv
module txdma_status
    import txdma_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   empty_i,
    input  logic [N_CH-1:0]   pend_i,
    output logic [DATA_W-1:0] status_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o                         <= '0;
            status_o[EMPTY_LSB  +: N_CH]     <= empty_i;
            status_o[NOPEND_LSB +: N_CH]     <= ~pend_i;
        end
    end

    // R9
    status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[EMPTY_LSB +: N_CH] == $past(empty_i)
                  && status_o[NOPEND_LSB +: N_CH] == ~$past(pend_i)));
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int STRIDE      = 32,
    parameter int STATUS_ADDR = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   frm_start,
    input  logic [N_CH-1:0]   frm_end,
    input  logic [N_CH-1:0]   buf_empty,
    input  logic [N_CH-1:0]   req_pend,
    output logic [N_CH-1:0]   chan_run,
    output logic [DATA_W-1:0] status
);
    logic [1:0]      mode  [N_CH];
    logic [N_CH-1:0] reqen;

    txdma_cfg_regs #(
        .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STRIDE(STRIDE), .STATUS_ADDR(STATUS_ADDR)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .status_i(status), .rdata_o(bus_rdata),
        .mode_o(mode), .reqen_o(reqen)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        txdma_chan_fsm i_fsm (
            .clk(clk), .rst_n(rst_n), .mode_i(mode[g]), .reqen_i(reqen[g]),
            .frm_start_i(frm_start[g]), .frm_end_i(frm_end[g]),
            .run_o(chan_run[g])
        );
    end

    txdma_status #(.N_CH(N_CH), .DATA_W(DATA_W)) i_stat (
        .clk(clk), .rst_n(rst_n), .empty_i(buf_empty), .pend_i(req_pend),
        .status_o(status)
    );

    // R5
    reqen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_run & ~reqen) == '0);
endmodule

// File: tb/test_txdma_ctrl.sv
`timescale 1ns/1ps
module test_txdma_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  frm_start = '0, frm_end = '0, buf_empty = '0, req_pend = '0;
    logic [7:0]  chan_run;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    txdma_ctrl i_txdma_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frm_start(frm_start),
        .frm_end(frm_end), .buf_empty(buf_empty), .req_pend(req_pend),
        .chan_run(chan_run), .status(status)
    );

    // reference model: 0 off, 1 running, 2 draining
    int     m_st   [8];
    int     m_mode [8];
    bit     m_en   [8];
    bit     m_inf  [8];
    logic [31:0] m_stat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin
                m_st[c] = 0; m_mode[c] = 0; m_en[c] = 0; m_inf[c] = 0;
            end
            m_stat = '0;
        end else begin
            for (int c = 0; c < 8; c++) begin
                int ns;
                ns = m_st[c];
                if (m_st[c] == 0) begin
                    if (m_mode[c] == 2) ns = 1;
                end else if (m_st[c] == 1) begin
                    if (m_mode[c] == 1) ns = (m_inf[c] && !frm_end[c]) ? 2 : 0;
                    else if (m_mode[c] != 2) ns = 0;
                end else begin
                    if (m_mode[c] == 2) ns = 1;
                    else if (m_mode[c] != 1 || frm_end[c]) ns = 0;
                end
                m_st[c] = ns;
                if (frm_start[c]) m_inf[c] = 1;
                else if (frm_end[c]) m_inf[c] = 0;
            end
            if (bus_wr && bus_addr < 12'h100 && bus_addr[4:0] == 0) begin
                m_mode[bus_addr[7:5]] = int'(bus_wdata[31:30]);
                m_en[bus_addr[7:5]]   = bus_wdata[3];
            end
            m_stat = {buf_empty, ~req_pend, 16'h0};
        end
    end

    // per-clock comparison of run and status (R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_run;
            for (int c = 0; c < 8; c++) exp_run[c] = (m_st[c] != 0) && m_en[c];
            checks++;
            if (chan_run !== exp_run) begin
                fails++;
                $display("FAIL R_model run: actual %h expected %h at %0t", chan_run, exp_run, $time);
            end
            checks++;
            if (status !== m_stat) begin
                fails++;
                $display("FAIL R9 status: actual %h expected %h at %0t", status, m_stat, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", {24'h0, chan_run}, 32'h0);
        for (int c = 0; c < 8; c++) rd_chk("R1 cfg", 12'(c * 32), 32'h0);

        // R2 readback and reserved bits
        wr(12'h000, 32'h8000_0008);
        rd_chk("R2 ch0", 12'h000, 32'h8000_0008);
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk("R2 ch1 reserved", 12'h020, 32'hC000_0008);
        tick();
        // R4 ch0 running; R6 mode 11 keeps ch1 off; R3 others idle
        chk("R4 run", {24'h0, chan_run}, 32'h1);
        rd_chk("R3 ch2 untouched", 12'h040, 32'h0);

        // R5 request enable clear
        wr(12'h040, 32'h8000_0000);
        tick(); tick();
        chk("R5 run2 low", {31'h0, chan_run[2]}, 32'h0);

        // R8 drain mid-frame on ch0
        frm_start[0] = 1'b1; tick(); frm_start[0] = 1'b0;
        wr(12'h000, 32'h4000_0008);
        tick(); tick(); tick();
        chk("R8 still running", {31'h0, chan_run[0]}, 32'h1);
        frm_end[0] = 1'b1; tick(); frm_end[0] = 1'b0;
        chk("R8 stopped after end", {31'h0, chan_run[0]}, 32'h0);

        // R7 pause between frames on ch3
        wr(12'h060, 32'h8000_0008);
        tick();
        chk("R7 ch3 up", {31'h0, chan_run[3]}, 32'h1);
        wr(12'h060, 32'h4000_0008);
        tick();
        chk("R7 ch3 stopped", {31'h0, chan_run[3]}, 32'h0);
        wr(12'h0A0, 32'h4000_0008);
        tick(); tick();
        chk("R7 no start", {31'h0, chan_run[5]}, 32'h0);

        // R6 hard stop mid-frame on ch4
        wr(12'h080, 32'h8000_0008);
        frm_start[4] = 1'b1; tick(); frm_start[4] = 1'b0;
        wr(12'h080, 32'h0);
        tick();
        chk("R6 hard stop", {31'h0, chan_run[4]}, 32'h0);

        // R9 status packing, ignored writes
        buf_empty = 8'hA5; req_pend = 8'h0F;
        tick();
        rd_chk("R9 status", 12'h100, 32'hA5F0_0000);
        chk("R9 idle ch", {24'h0, status[31:24] & status[23:16]}, 32'hA0);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        rd_chk("R9 status unchanged", 12'h100, 32'hA5F0_0000);
        rd_chk("R9 unmapped", 12'h004, 32'h0);
        rd_chk("R3 ch0 intact", 12'h000, 32'h4000_0008);
        buf_empty = 8'h3C; req_pend = 8'hF0;
        tick();
        rd_chk("R9 status 2", 12'h100, 32'h3C0F_0000);
        tick(); tick();
        finish_run();
    end
endmodule